// File: doc/BRIEF.md
# Page Translation Buffer with Handler Refill

This block translates virtual addresses into 30-bit physical addresses through a small, fully associative table of recent page translations. A requested lookup compares the virtual page number against every valid slot in parallel. On a match, the block returns the physical address in the same cycle. The physical address is the stored 18-bit physical page number followed by the 12-bit page offset, which is copied unchanged from the virtual address.

If no slot matches, the block does not walk any page table. It raises a registered miss exception and waits. An external handler reads the translation from memory and writes it through a dedicated refill port. The requester then retries. Only translations for pages resident in main memory are ever written, so every hit yields a main-memory address.

Victims for refill are chosen by a round-robin slot pointer. A refill whose virtual page number is already present overwrites that slot in place. A flush input empties the whole table in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, no slot is valid, `lk_miss_exc` is low and the round-robin pointer is at slot 0, so the first refill lands in slot 0.
- R2: When `lk_req` is high and the virtual page number (`lk_vaddr[31:12]`) matches a valid slot, `lk_hit` is high in the same cycle and `lk_paddr[29:12]` equals that slot's 18-bit physical page number.
- R3: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`.
- R4: `lk_miss_exc` is a register. It is high in the cycle after a cycle in which `lk_req` was high, no slot matched and no refill was accepted. It stays high for as long as the request keeps missing.
- R5: `lk_miss_exc` falls in the cycle after `lk_req` is withdrawn.
- R6: A refill is accepted when `fill_we` is high and `flush` is low. It is visible from the next cycle: a retried lookup of that page hits, and `lk_miss_exc` is low.
- R7: An accepted refill of a page not held in any valid slot writes the slot under the pointer. The pointer then advances by one and wraps after slot 7. With 8 slots, the ninth distinct refill evicts the first page installed.
- R8: An accepted refill of a page already held in a valid slot overwrites that slot's physical page number and leaves the pointer unchanged.
- R9: `flush` clears every valid bit at the next edge and returns the pointer to slot 0. A refill presented in the same cycle is dropped. A lookup in the flush cycle itself still sees the old contents.
- R10: Whenever `lk_hit` is low, including when `lk_req` is low, `lk_paddr` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request valid |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found this cycle |
| lk_paddr | output | 30 | Physical address, zero when no hit |
| lk_miss_exc | output | 1 | Registered miss exception |
| fill_we | input | 1 | Refill write strobe from the handler |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 18 | Physical page number being installed |
| flush | input | 1 | Invalidate all slots |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Ninth distinct refill.** A wrong wrap or a stuck pointer evicts the wrong page, or none, and lookups of the first page keep hitting.
- **Re-refill of a resident page.** A design that misses the in-place overwrite creates duplicate slots or advances the pointer. This later evicts a page the model still expects to hit.
- **Flush combined with a refill.** A design that lets the refill through, or that keeps the old pointer, hits after the flush or fills the wrong slot.
- **Exception timing.** A combinational exception, an exception not cleared by withdrawal, or an exception not cleared by refill shows up one cycle off the model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VA_W    = 32;
  localparam int unsigned TLB_PA_W    = 30;
  localparam int unsigned TLB_OFS_W   = 12;
  localparam int unsigned TLB_ENTRIES = 8;

  // next round-robin slot, wrapping for any entry count
  function automatic int unsigned rr_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  // lowest index wins; duplicates are prevented by the refill path
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (adv)   ptr <= IDX_W'(tlb_pkg::rr_next(int'(ptr), ENTRIES));
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 18,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_all,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [VPN_W-1:0]              wvpn,
  input  logic [PPN_W-1:0]              wppn,
  output logic [ENTRIES-1:0]            valid,
  output logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic [ENTRIES-1:0][PPN_W-1:0] ppns
);
  // valid bits need reset and single-cycle clear
  always_ff @(posedge clk) begin
    if (rst || clr_all) valid <= '0;
    else if (we)        valid[widx] <= 1'b1;
  end

  // payload carries no reset; guarded by valid
  always_ff @(posedge clk) begin
    if (we) begin
      tags[widx] <= wvpn;
      ppns[widx] <= wppn;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int unsigned VA_W    = tlb_pkg::TLB_VA_W,
  parameter int unsigned PA_W    = tlb_pkg::TLB_PA_W,
  parameter int unsigned OFS_W   = tlb_pkg::TLB_OFS_W,
  parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_req,
  input  logic [VA_W-1:0]         lk_vaddr,
  output logic                    lk_hit,
  output logic [PA_W-1:0]         lk_paddr,
  output logic                    lk_miss_exc,
  input  logic                    fill_we,
  input  logic [VA_W-OFS_W-1:0]   fill_vpn,
  input  logic [PA_W-OFS_W-1:0]   fill_ppn,
  input  logic                    flush
);
  localparam int unsigned VPN_W = VA_W - OFS_W;
  localparam int unsigned PPN_W = PA_W - OFS_W;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0][PPN_W-1:0] ppns;
  logic                          look_hit, fill_hit;
  logic [IDX_W-1:0]              look_idx, fill_idx, rr_ptr, widx;
  logic                          fill_ok, miss_q;

  assign fill_ok = fill_we && !flush;
  assign widx    = fill_hit ? fill_idx : rr_ptr;

  tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst(rst), .clr_all(flush), .we(fill_ok), .widx(widx),
    .wvpn(fill_vpn), .wppn(fill_ppn), .valid(valid), .tags(tags), .ppns(ppns)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_look (
    .valid(valid), .tags(tags), .key(lk_vaddr[VA_W-1:OFS_W]),
    .hit(look_hit), .idx(look_idx)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill (
    .valid(valid), .tags(tags), .key(fill_vpn),
    .hit(fill_hit), .idx(fill_idx)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst(rst), .clr(flush), .adv(fill_ok && !fill_hit), .ptr(rr_ptr)
  );

  assign lk_hit   = lk_req && look_hit;
  assign lk_paddr = lk_hit ? {ppns[look_idx], lk_vaddr[OFS_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (rst) miss_q <= 1'b0;
    else     miss_q <= lk_req && !look_hit && !fill_ok;
  end
  assign lk_miss_exc = miss_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 30,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned ENTRIES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_req,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  lk_hit,
  input logic [PA_W-1:0]       lk_paddr,
  input logic                  lk_miss_exc,
  input logic                  fill_we,
  input logic [VA_W-OFS_W-1:0] fill_vpn,
  input logic [PA_W-OFS_W-1:0] fill_ppn,
  input logic                  flush
);
  AST_MISS_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    lk_miss_exc |-> $past(lk_req && !lk_hit)); // R4
  AST_MISS_DROPS_ON_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_miss_exc); // R5
  AST_MISS_DROPS_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    (fill_we && !flush) |=> !lk_miss_exc); // R6
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (fill_we && !flush) |=>
      (!(lk_req && lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn)) ||
       (lk_hit && lk_paddr[PA_W-1:OFS_W] == $past(fill_ppn)))); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit); // R9
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R3
  AST_ZERO_WITHOUT_HIT: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_paddr == '0); // R10
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int N = 8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss_exc;
  logic [29:0] lk_paddr;
  logic        fill_we = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic        flush = 1'b0;

  int vectors = 0;
  int errors  = 0;

  // bench model
  logic        m_valid [N];
  logic [19:0] m_vpn   [N];
  logic [17:0] m_ppn   [N];
  int          m_ptr;
  logic        m_miss;

  always #5 clk = ~clk;

  tlb_xlate u_tlb_xlate (.*);

  function automatic int find(logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive, check outputs against model, then advance model at the edge
  task automatic step(string tag, logic req, logic [31:0] va, logic we,
                      logic [19:0] fv, logic [17:0] fp, logic fl);
    int          k;
    logic        eh;
    logic [29:0] ep;
    @(negedge clk);
    lk_req = req; lk_vaddr = va; fill_we = we; fill_vpn = fv; fill_ppn = fp; flush = fl;
    #2;
    k  = find(va[31:12]);
    eh = req && (k >= 0);
    ep = eh ? {m_ppn[k], va[11:0]} : 30'd0;
    check(tag, "hit", 32'(lk_hit), 32'(eh));
    check(tag, "paddr", 32'(lk_paddr), 32'(ep));
    check(tag, "miss_exc", 32'(lk_miss_exc), 32'(m_miss));
    @(posedge clk);
    m_miss = req && !eh && !(we && !fl);
    if (fl) begin
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
      m_ptr = 0;
    end else if (we) begin
      k = find(fv);
      if (k >= 0) m_ppn[k] = fp;
      else begin
        m_valid[m_ptr] = 1'b1; m_vpn[m_ptr] = fv; m_ppn[m_ptr] = fp;
        m_ptr = (m_ptr + 1) % N;
      end
    end
  endtask

  function automatic logic [31:0] va_of(logic [19:0] v);
    return {v, 12'($urandom_range(0, 4095))};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; end
    m_ptr = 0; m_miss = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: empty after reset, no exception
    step("R1", 1'b0, 32'h0, 1'b0, '0, '0, 1'b0);
    // R4: missing lookup raises and holds exception
    step("R4", 1'b1, 32'h1234_5678, 1'b0, '0, '0, 1'b0);
    step("R4", 1'b1, 32'h1234_5678, 1'b0, '0, '0, 1'b0);
    step("R4", 1'b1, 32'h1234_5678, 1'b0, '0, '0, 1'b0);
    // R5: withdrawal clears it
    step("R5", 1'b0, 32'h1234_5678, 1'b0, '0, '0, 1'b0);
    step("R5", 1'b0, 32'h0, 1'b0, '0, '0, 1'b0);
    // R6: miss, refill, retry hits (R2, R3 checked on the hit)
    step("R6", 1'b1, 32'h1234_5ABC, 1'b0, '0, '0, 1'b0);
    step("R6", 1'b1, 32'h1234_5ABC, 1'b1, 20'h12345, 18'h2_BEEF, 1'b0);
    step("R2", 1'b1, 32'h1234_5ABC, 1'b0, '0, '0, 1'b0);
    step("R3", 1'b1, 32'h1234_5FFF, 1'b0, '0, '0, 1'b0);
    // R10: no request gives zero address even for a resident page
    step("R10", 1'b0, 32'h1234_5ABC, 1'b0, '0, '0, 1'b0);
    // R7: fill to wrap, ninth distinct page evicts the first
    for (int i = 1; i <= 8; i++)
      step("R7", 1'b0, '0, 1'b1, 20'(20'h50000 + i), 18'(i * 3), 1'b0);
    step("R7", 1'b1, 32'h1234_5000, 1'b0, '0, '0, 1'b0);
    step("R7", 1'b1, 32'h5000_1010, 1'b0, '0, '0, 1'b0);
    // R8: re-refill of a resident page overwrites in place
    step("R8", 1'b0, '0, 1'b1, 20'h50004, 18'h3_0004, 1'b0);
    step("R8", 1'b1, 32'h5000_4321, 1'b0, '0, '0, 1'b0);
    step("R8", 1'b0, '0, 1'b1, 20'h60000, 18'h111, 1'b0);
    step("R8", 1'b1, 32'h5000_2000, 1'b0, '0, '0, 1'b0);
    step("R8", 1'b1, 32'h5000_3000, 1'b0, '0, '0, 1'b0);
    // R9: lookup in flush cycle still hits, refill dropped, then empty
    step("R9", 1'b1, 32'h5000_5000, 1'b1, 20'h70000, 18'h7, 1'b1);
    step("R9", 1'b1, 32'h5000_5000, 1'b0, '0, '0, 1'b0);
    step("R9", 1'b1, 32'h7000_0000, 1'b0, '0, '0, 1'b0);
    step("R9", 1'b0, '0, 1'b1, 20'h70001, 18'h9, 1'b0);
    step("R9", 1'b1, 32'h7000_1AAA, 1'b0, '0, '0, 1'b0);

    // constrained random: small page pool to force hits, evictions, overwrites
    for (int n = 0; n < 4000; n++) begin
      logic [19:0] rv, fv;
      rv = 20'(20'h80000 + $urandom_range(0, 11));
      fv = 20'(20'h80000 + $urandom_range(0, 11));
      step("R2", 1'($urandom_range(0, 3) != 0), va_of(rv),
           1'($urandom_range(0, 3) == 0), fv, 18'($urandom),
           1'($urandom_range(0, 99) == 0));
    end
    finish_run();
  end
endmodule